// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns a master clock into the bit timing of a CAN node. A programmable divider cuts the clock into time quanta. Each bit is built from four segments, one after another: a one-quantum sync segment, a propagation segment, phase 1 and phase 2. At the end of phase 1 the received line is sampled, either once or as a three-sample majority vote. A pulse at the start of every sync segment tells the transmitter when to drive its next bit.

While enabled and not yet locked, the first recessive-to-dominant edge on the line performs a hard synchronization that starts a new bit at once. After that, recessive-to-dominant edges pull the bit grid back into line. An edge that arrives late stretches phase 1. An edge that arrives early trims phase 2. The change is limited to the jump width, and happens at most once per bit. The timing word is captured only while the unit is disabled, and a zero-length phase 2 setting is reported as a configuration error.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts Q = BRP+1 clocks, with BRP in cfg_word[22:16]. With no line edges, tx_strobe pulses every N*Q clocks, where N = 4+PROP+PH1+PH2. The fields are PROP cfg_word[10:8], PH1 cfg_word[6:4] and PH2 cfg_word[2:0].
- R2: While the unit is enabled and not synchronized, a falling rx gives a one-clock tx_strobe on the second rising clock edge after rx goes low (hard synchronization).
- R3: sample_strobe pulses Q*(3+PROP+PH1)+1 clocks after the tx_strobe clock of the same bit, and sampled_bit holds the new value while the strobe is high.
- R4: With cfg_word[24] = 0, sampled_bit is the rx level seen in the last clock of phase 1. With cfg_word[24] = 1, it is the majority of that level and the levels one clock before and one clock after.
- R5: When BRP is 0, majority sampling is off whatever cfg_word[24] holds.
- R6: rx is captured in one register. An edge seen in that register d clocks after the tx_strobe clock lies in quantum k = floor(d/Q). If the edge falls in the propagation segment or phase 1, that bit lasts (N+min(k, SJW+1))*Q clocks, with SJW in cfg_word[13:12].
- R7: If the edge falls in phase 2 and N-k > SJW+1, that bit lasts (N-SJW-1)*Q clocks. Otherwise the next tx_strobe comes at d+1.
- R8: Edges inside the sync segment and rising rx edges leave the bit length unchanged.
- R9: Only the first qualifying falling edge in a bit adjusts its timing. Later edges in the same bit are ignored.
- R10: cfg_word is taken in only while enable is low. Changes made while enable is high do not change the timing.
- R11: A PH2 field of 0 drives cfg_error high while enabled. In that case neither strobe pulses.
- R12: After reset, and while enable is low, no strobe pulses and cfg_error is low. After reset, sampled_bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the unit; low clears synchronization and opens the configuration capture |
| rx | input | 1 | Received bus line, 1 = recessive |
| cfg_word | input | 32 | Timing configuration word |
| sampled_bit | output | 1 | Most recently sampled bit value |
| sample_strobe | output | 1 | One-clock pulse when sampled_bit is updated |
| tx_strobe | output | 1 | One-clock pulse at the start of each sync segment |
| cfg_error | output | 1 | Captured PH2 field is zero while enabled |

## Verification
The assertions check on every cycle that the divider never counts past its limit and that the adjusted segment counter stays within reach of the jump width. They also check that the captured configuration never moves while the unit is enabled, that no transmit strobe appears while disabled or misconfigured, and that single sampling returns the line level from two clocks earlier. Bit lengths after late, early and sync-segment edges, the one-adjustment-per-bit rule, majority voting against one- and two-clock glitches, and the exact strobe positions depend on where edges fall within a bit. Only the bench scenarios show these, by timing strobes against values computed from the configuration.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    localparam int CFG_W  = 32;
    localparam int BRP_W  = 7;
    localparam int SEG_W  = 3;
    localparam int SJW_W  = 2;
    localparam int QW     = 5;   // holds segment length plus jump width and phase error

    typedef enum logic [1:0] {SEG_SYNC, SEG_PROP, SEG_PH1, SEG_PH2} seg_e;

    typedef struct packed {
        logic             triple;
        logic [BRP_W-1:0] brp;
        logic [SJW_W-1:0] sjw;
        logic [SEG_W-1:0] prop;
        logic [SEG_W-1:0] ph1;
        logic [SEG_W-1:0] ph2;
    } bt_cfg_t;

    function automatic bt_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        bt_cfg_t c;
        c.triple = w[24];
        c.brp    = w[22:16];
        c.sjw    = w[13:12];
        c.prop   = w[10:8];
        c.ph1    = w[6:4];
        c.ph2    = w[2:0];
        return c;
    endfunction
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [BRP_W-1:0] div,
    output logic             tick
);
    logic [BRP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || restart || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_div_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic triple,
    input  logic sp_pulse,
    output logic rx_fall,
    output logic bit_out,
    output logic strobe
);
    typedef struct packed {
        logic rx_s;
        logic d1;
        logic d2;
        logic bit_v;
        logic stb;
    } smp_st_t;

    smp_st_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.rx_s = rx;
        s_d.d1   = s_q.rx_s;
        s_d.d2   = s_q.d1;
        s_d.stb  = sp_pulse;
        if (sp_pulse) begin
            if (triple)
                s_d.bit_v = (s_q.d2 & s_q.d1) | (s_q.d1 & s_q.rx_s) | (s_q.d2 & s_q.rx_s);
            else
                s_d.bit_v = s_q.d1;
        end
        rx_fall = s_q.d1 & ~s_q.rx_s;
        bit_out = s_q.bit_v;
        strobe  = s_q.stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{rx_s: 1'b1, d1: 1'b1, d2: 1'b1, bit_v: 1'b1, stb: 1'b0};
        else        s_q <= s_d;
    end

    assert_single_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stb && !$past(triple)) |-> (s_q.bit_v == $past(s_q.rx_s, 2)));
endmodule

// File: rtl/can_bt_sequencer.sv
module can_bt_sequencer
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    cfg_ok,
    input  bt_cfg_t cfg,
    input  logic    tick,
    input  logic    rx_fall,
    output logic    run,
    output logic    restart,
    output logic    tx_pulse,
    output logic    sp_pulse
);
    localparam int QL_MAX = (2**SEG_W - 1) + 2**SJW_W;

    typedef struct packed {
        seg_e          seg;
        logic [QW-1:0] qleft;
        logic [QW-1:0] ext;
        logic          synced;
        logic          resynced;
        logic          tx;
        logic          sp;
    } seq_st_t;

    seq_st_t s_q, s_d;
    logic [QW-1:0] ql, ex, err, jw, e;
    logic          jump;

    always_comb begin
        s_d     = s_q;
        s_d.tx  = 1'b0;
        s_d.sp  = 1'b0;
        restart = 1'b0;
        jump    = 1'b0;
        ql      = s_q.qleft;
        ex      = s_q.ext;
        jw      = QW'(cfg.sjw) + 1'b1;
        case (s_q.seg)
            SEG_PROP: err = QW'(cfg.prop) + 1'b1 - s_q.qleft;
            SEG_PH1:  err = QW'(cfg.prop) + QW'(cfg.ph1) + 2'd2 - s_q.qleft;
            SEG_PH2:  err = s_q.qleft + 1'b1;
            default:  err = '0;
        endcase
        e = (err < jw) ? err : jw;

        if (!enable || !cfg_ok) begin
            s_d = '0;
        end else if (!s_q.synced) begin
            if (rx_fall) begin
                s_d.synced   = 1'b1;
                s_d.resynced = 1'b0;
                s_d.seg      = SEG_SYNC;
                s_d.qleft    = '0;
                s_d.ext      = '0;
                s_d.tx       = 1'b1;
            end
        end else begin
            if (rx_fall && !s_q.resynced && s_q.seg != SEG_SYNC) begin
                s_d.resynced = 1'b1;
                case (s_q.seg)
                    SEG_PROP: ex = e;
                    SEG_PH1:  ql = ql + e;
                    SEG_PH2:  if (e == err) jump = 1'b1;
                              else          ql = ql - e;
                    default:  ;
                endcase
            end
            s_d.qleft = ql;
            s_d.ext   = ex;
            if (jump) begin
                s_d.seg      = SEG_SYNC;
                s_d.qleft    = '0;
                s_d.ext      = '0;
                s_d.resynced = 1'b0;
                s_d.tx       = 1'b1;
                restart      = 1'b1;
            end else if (tick) begin
                if (ql == '0) begin
                    case (s_q.seg)
                        SEG_SYNC: begin
                            s_d.seg   = SEG_PROP;
                            s_d.qleft = QW'(cfg.prop);
                        end
                        SEG_PROP: begin
                            s_d.seg   = SEG_PH1;
                            s_d.qleft = QW'(cfg.ph1) + ex;
                        end
                        SEG_PH1: begin
                            s_d.seg   = SEG_PH2;
                            s_d.qleft = QW'(cfg.ph2);
                            s_d.sp    = 1'b1;
                        end
                        default: begin
                            s_d.seg      = SEG_SYNC;
                            s_d.qleft    = '0;
                            s_d.ext      = '0;
                            s_d.resynced = 1'b0;
                            s_d.tx       = 1'b1;
                        end
                    endcase
                end else begin
                    s_d.qleft = ql - 1'b1;
                end
            end
        end
        run      = s_q.synced;
        tx_pulse = s_q.tx;
        sp_pulse = s_q.sp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_no_tx_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !s_q.tx);
    assert_jump_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.qleft <= QW'(QL_MAX));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rx,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             sampled_bit,
    output logic             sample_strobe,
    output logic             tx_strobe,
    output logic             cfg_error
);
    bt_cfg_t cfg_d, cfg_q;
    logic    cfg_ok, triple_eff, tick, run, restart, rx_fall, sp_pulse;

    always_comb begin
        cfg_d      = enable ? cfg_q : unpack_cfg(cfg_word);
        cfg_ok     = (cfg_q.ph2 != '0);
        triple_eff = cfg_q.triple && (cfg_q.brp != '0);
        cfg_error  = enable && !cfg_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    can_bt_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .div     (cfg_q.brp),
        .tick    (tick)
    );

    can_bt_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cfg_ok   (cfg_ok),
        .cfg      (cfg_q),
        .tick     (tick),
        .rx_fall  (rx_fall),
        .run      (run),
        .restart  (restart),
        .tx_pulse (tx_strobe),
        .sp_pulse (sp_pulse)
    );

    can_bt_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx       (rx),
        .triple   (triple_eff),
        .sp_pulse (sp_pulse),
        .rx_fall  (rx_fall),
        .bit_out  (sampled_bit),
        .strobe   (sample_strobe)
    );

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_q));
    assert_err_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (!tx_strobe && !sample_strobe));
endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        rx = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        sampled_bit, sample_strobe, tx_strobe, cfg_error;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int bp, pp, f1, f2, sj, sm;
    int t0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx(rx), .cfg_word(cfg_word),
        .sampled_bit(sampled_bit), .sample_strobe(sample_strobe),
        .tx_strobe(tx_strobe), .cfg_error(cfg_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(int b, int p, int a, int c, int s, int m);
        return {7'b0, 1'(m), 1'b0, 7'(b), 2'b0, 2'(s), 1'b0, 3'(p), 1'b0, 3'(a), 1'b0, 3'(c)};
    endfunction

    function automatic int qlen();   return bp + 1;                endfunction
    function automatic int nbits();  return 4 + pp + f1 + f2;      endfunction
    function automatic int smp_off(); return qlen() * (3 + pp + f1) + 1; endfunction

    function automatic int exp_next(int d);
        int q = qlen();
        int n = nbits();
        int k = d / q;
        int e, rem;
        if (k == 0) return n * q;
        if (k <= pp + f1 + 2) begin
            e = (k < sj + 1) ? k : sj + 1;
            return (n + e) * q;
        end
        rem = n - k;
        e = (rem < sj + 1) ? rem : sj + 1;
        if (e == rem) return d + 1;
        return (n - e) * q;
    endfunction

    task automatic wait_cyc(int abs);
        while (cyc < abs) @(negedge clk);
    endtask

    task automatic find_tx(output int t);
        int lim = cyc + 4000;
        do @(negedge clk); while (!tx_strobe && cyc < lim);
        t = tx_strobe ? cyc : -1;
    endtask

    task automatic find_smp(output int t, output logic b);
        int lim = cyc + 4000;
        do @(negedge clk); while (!sample_strobe && cyc < lim);
        t = sample_strobe ? cyc : -1;
        b = sampled_bit;
    endtask

    task automatic start();
        int h, t;
        enable = 1'b0;
        rx = 1'b1;
        cfg_word = pack(bp, pp, f1, f2, sj, sm);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        rx = 1'b0;
        h = cyc;
        find_tx(t);
        chk(t == h + 2, "R2 hard sync", t - h, 2);
        t0 = t;
    endtask

    task automatic glitch(int len, logic exp, string req);
        int dsp = qlen() * (3 + pp + f1) - 1;
        int t;
        logic b;
        wait_cyc(t0 + dsp - len);
        rx = 1'b1;
        wait_cyc(t0 + dsp);
        rx = 1'b0;
        find_smp(t, b);
        chk(t - t0 == smp_off(), "R3 sample position", t - t0, smp_off());
        chk(b == exp, req, b, exp);
    endtask

    task automatic count_quiet(int ncyc, output int cnt);
        cnt = 0;
        repeat (ncyc) begin
            @(negedge clk);
            if (tx_strobe || sample_strobe) cnt++;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int t, t2, d, cnt, mode, k;
        logic b;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_strobe == 0 && sample_strobe == 0, "R12 reset strobes", tx_strobe + sample_strobe, 0);
        chk(cfg_error == 0, "R12 reset cfg_error", cfg_error, 0);
        chk(sampled_bit == 1, "R12 reset sampled_bit", sampled_bit, 1);

        // random configurations with idle line or a single resynchronizing edge
        for (int it = 0; it < 24; it++) begin
            bp = 1 + $urandom % 5; pp = $urandom % 8; f1 = $urandom % 8;
            f2 = 1 + $urandom % 7; sj = $urandom % 4; sm = $urandom % 2;
            start();
            mode = $urandom % 2;
            if (mode == 0) begin
                find_smp(t, b);
                chk(t - t0 == smp_off(), "R3 sample offset", t - t0, smp_off());
                chk(b == 1'b0, "R4 dominant sample", b, 0);
                find_tx(t);
                chk(t - t0 == nbits() * qlen(), "R1 nominal bit", t - t0, nbits() * qlen());
                find_tx(t2);
                chk(t2 - t == nbits() * qlen(), "R1 second bit", t2 - t, nbits() * qlen());
            end else begin
                d = 2 + $urandom % (nbits() * qlen() - 2);
                k = d / qlen();
                rx = 1'b1;
                wait_cyc(t0 + d - 1);
                rx = 1'b0;
                find_tx(t);
                if (k == 0)                 chk(t - t0 == exp_next(d), "R8 sync edge", t - t0, exp_next(d));
                else if (k <= pp + f1 + 2)  chk(t - t0 == exp_next(d), "R6 late edge", t - t0, exp_next(d));
                else                        chk(t - t0 == exp_next(d), "R7 early edge", t - t0, exp_next(d));
                find_tx(t2);
                chk(t2 - t == nbits() * qlen(), "R1 bit after resync", t2 - t, nbits() * qlen());
            end
        end

        // edge inside the sync segment
        bp = 3; pp = 2; f1 = 2; f2 = 2; sj = 3; sm = 0;
        start();
        rx = 1'b1; wait_cyc(t0 + 2); rx = 1'b0;
        find_tx(t);
        chk(t - t0 == nbits() * qlen(), "R8 sync segment edge", t - t0, nbits() * qlen());

        // glitches at the sample point
        bp = 3; pp = 1; f1 = 1; f2 = 2; sj = 0; sm = 1;
        start(); glitch(1, 1'b0, "R4 triple rejects glitch");
        sm = 0;
        start(); glitch(1, 1'b1, "R4 single sees glitch");
        sm = 1;
        start(); glitch(2, 1'b1, "R4 triple majority high");
        bp = 0; sm = 1;
        start(); glitch(1, 1'b1, "R5 triple off at BRP 0");

        // two edges in one bit
        bp = 1; pp = 2; f1 = 3; f2 = 3; sj = 1; sm = 0;
        start();
        rx = 1'b1; wait_cyc(t0 + 3); rx = 1'b0;
        wait_cyc(t0 + 5); rx = 1'b1;
        wait_cyc(t0 + 13); rx = 1'b0;
        find_tx(t);
        chk(t - t0 == 28, "R9 second edge ignored", t - t0, 28);

        // configuration change while enabled
        bp = 2; pp = 1; f1 = 2; f2 = 2; sj = 0; sm = 0;
        start();
        cfg_word = pack(5, 7, 7, 7, 3, 1);
        find_tx(t);
        chk(t - t0 == 27, "R10 write ignored", t - t0, 27);
        find_tx(t2);
        chk(t2 - t == 27, "R10 write ignored later", t2 - t, 27);

        // illegal phase 2
        enable = 1'b0;
        cfg_word = pack(2, 1, 1, 0, 0, 0);
        rx = 1'b1;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(cfg_error == 1, "R11 cfg_error set", cfg_error, 1);
        rx = 1'b0;
        count_quiet(150, cnt);
        chk(cnt == 0, "R11 no strobes", cnt, 0);
        enable = 1'b0;
        @(negedge clk);
        chk(cfg_error == 0, "R12 cfg_error off when disabled", cfg_error, 0);

        // disable while running
        bp = 1; pp = 1; f1 = 1; f2 = 1; sj = 0; sm = 0;
        start();
        enable = 1'b0;
        rx = 1'b1;
        repeat (5) @(negedge clk);
        rx = 1'b0;
        count_quiet(150, cnt);
        chk(cnt == 0, "R12 quiet when disabled", cnt, 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule